// File: doc/BRIEF.md
# Control/Status Register File with Segment Execute Guard

This block holds the eight byte-wide control and status registers of a small accumulator core. The core sends a 3-bit register select, a write strobe and write data, and reads back a byte from a combinational read path. The block also has two other jobs. It checks every instruction fetch against a 16-bit map of per-segment execute permissions, and it keeps a 16-bit tick counter. Software can preset that counter, and it steps once for each instruction the core retires while counting is enabled.

The program address space is split into sixteen equal segments, indexed by the top four bits of the fetch address. The low permission register covers segments 0 to 7 and the high one covers segments 8 to 15. When a fetch targets a segment whose bit is clear, the block raises `fetch_denied` in the same cycle, and the core then halts. After reset only segment 0 is executable, so the boot code can run and open up further segments. The control register drives an interrupt line and six outgoing signal bits, and holds the counter enable. Two registers are read-only views of external inputs: a general input byte and a host signal byte.

All pins are plain control and status pins. There is no data stream here and no handshake: a write takes effect at the clock edge where `csr_we` is high, and a read is valid in the same cycle as its select.

Top module: `csr_seg_file`

## Requirements
- R1: After reset, register 0 (low execute map) reads 0x01. Registers 1, 3, 4, 5 and 6 read 0x00. `io_out`, `sig_out`, `irq_out` and `fetch_denied` are 0.
- R2: `csr_rdata` is combinational on `csr_sel`. Select 0 reads the low execute map, 1 the high execute map, 2 `io_in`, 3 the output register, 4 the counter low byte, 5 the counter high byte, 6 the control register and 7 `sig_in`.
- R3: `fetch_denied` is high exactly when `fetch_valid` is high and the execute bit of segment `fetch_pc[7:4]` is 0. Bit n of register 0 is segment n (0 to 7), and bit n of register 1 is segment 8+n.
- R4: With reset maps, a fetch in segment 0 is allowed and a fetch in any other segment is denied.
- R5: Control register (select 6): bit 0 drives `irq_out`, bits 7:2 drive `sig_out[5:0]`, and bit 1 enables the counter. The outputs follow a write from the next clock edge.
- R6: A write to select 3 appears on `io_out` from the next clock edge.
- R7: The counter advances by one at every edge where `retire` is high and the enable bit was already set before that edge. It holds when the enable is clear or `retire` is low. After the enable is written from a cleared count, one more retired instruction makes it read 1. A read made during the following retired instruction returns 1, and the read after that returns 2.
- R8: The count is 16 bits. The low byte carries into the high byte when it wraps from 0xFF, and 0xFFFF wraps to 0x0000.
- R9: A write to select 4 or 5 loads that byte. No increment happens at that edge, even with `retire` high, and the other byte keeps its value.
- R10: Writes to selects 2 and 7 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_sel | input | 3 | Register select |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data for `csr_sel` |
| retire | input | 1 | One pulse per retired instruction |
| fetch_valid | input | 1 | A fetch is being made this cycle |
| fetch_pc | input | 8 | Address being fetched |
| fetch_denied | output | 1 | Fetch targets a non-executable segment |
| io_in | input | 8 | General input byte |
| io_out | output | 8 | General output byte |
| sig_in | input | 8 | Incoming host signal bits |
| sig_out | output | 6 | Outgoing host signal bits |
| irq_out | output | 1 | Interrupt request to host |

## Verification
A corrupted execute-map bit shows on `fetch_denied` in the first cycle a fetch lands in that segment. It also shows at once on a read of the map register. A wrong counter state, such as a lost carry, a stale enable or an increment that collides with a preset, shows on the next read of the counter bytes. The bench reads the counter right after each retire pulse, so such an error is seen within one cycle. A wrong control or output register reaches `irq_out`, `sig_out` or `io_out` one edge after the write that set it, and the bench samples those pins in that cycle.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [2:0] {
    SEL_EXE_LO  = 3'd0,
    SEL_EXE_HI  = 3'd1,
    SEL_GP_IN   = 3'd2,
    SEL_GP_OUT  = 3'd3,
    SEL_TICK_LO = 3'd4,
    SEL_TICK_HI = 3'd5,
    SEL_CTRL    = 3'd6,
    SEL_HOST_IN = 3'd7
  } csr_sel_e;

  localparam int CTRL_IRQ_BIT  = 0;
  localparam int CTRL_TICK_BIT = 1;
  localparam int CTRL_SIG_LSB  = 2;
endpackage

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int MAP_W = 16,
  parameter int PC_W  = 8
) (
  input  logic [MAP_W-1:0] exe_map,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             denied
);
  localparam int IDX_W = $clog2(MAP_W);

  logic [IDX_W-1:0] seg_idx;
  logic [MAP_W-1:0] blocked_hit;

  assign seg_idx = fetch_pc[PC_W-1 -: IDX_W];

  for (genvar g = 0; g < MAP_W; g++) begin : g_seg
    assign blocked_hit[g] = (seg_idx == IDX_W'(g)) && !exe_map[g];
  end

  assign denied = fetch_valid && (|blocked_hit);
endmodule

// File: rtl/retire_counter.sv
module retire_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     step,
  input  logic [NBYTES-1:0]        byte_wr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [NBYTES*BYTE_W-1:0] count
);
  localparam int CNT_W = NBYTES * BYTE_W;

  logic [CNT_W-1:0] next_count;

  always_comb begin
    next_count = count;
    if (|byte_wr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (byte_wr[b]) next_count[b*BYTE_W +: BYTE_W] = wdata;
      end
    end else if (enable && step) begin
      next_count = count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count;
  end
endmodule

// File: rtl/csr_seg_file.sv
module csr_seg_file
  import csr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        csr_sel,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              retire,
  input  logic              fetch_valid,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              fetch_denied,
  input  logic [DATA_W-1:0] io_in,
  output logic [DATA_W-1:0] io_out,
  input  logic [DATA_W-1:0] sig_in,
  output logic [DATA_W-3:0] sig_out,
  output logic              irq_out
);
  localparam int MAP_W = 2 * DATA_W;
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] EXE_LO_RST = DATA_W'(1);

  logic [DATA_W-1:0] exe_lo_q, exe_hi_q, gp_out_q, ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        cnt_byte_wr;
  logic              cnt_en;
  logic [7:0]        wr_hit;

  for (genvar s = 0; s < 8; s++) begin : g_dec
    assign wr_hit[s] = csr_we && (csr_sel == 3'(s));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exe_lo_q <= EXE_LO_RST;
      exe_hi_q <= '0;
      gp_out_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_hit[SEL_EXE_LO]) exe_lo_q <= csr_wdata;
      if (wr_hit[SEL_EXE_HI]) exe_hi_q <= csr_wdata;
      if (wr_hit[SEL_GP_OUT]) gp_out_q <= csr_wdata;
      if (wr_hit[SEL_CTRL])   ctrl_q   <= csr_wdata;
    end
  end

  assign cnt_en      = ctrl_q[CTRL_TICK_BIT];
  assign cnt_byte_wr = {wr_hit[SEL_TICK_HI], wr_hit[SEL_TICK_LO]};

  retire_counter #(.BYTE_W(DATA_W), .NBYTES(2)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cnt_en),
    .step    (retire),
    .byte_wr (cnt_byte_wr),
    .wdata   (csr_wdata),
    .count   (cnt_q)
  );

  seg_guard #(.MAP_W(MAP_W), .PC_W(PC_W)) u_guard (
    .exe_map     ({exe_hi_q, exe_lo_q}),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .denied      (fetch_denied)
  );

  always_comb begin
    unique case (csr_sel_e'(csr_sel))
      SEL_EXE_LO:  csr_rdata = exe_lo_q;
      SEL_EXE_HI:  csr_rdata = exe_hi_q;
      SEL_GP_IN:   csr_rdata = io_in;
      SEL_GP_OUT:  csr_rdata = gp_out_q;
      SEL_TICK_LO: csr_rdata = cnt_q[DATA_W-1:0];
      SEL_TICK_HI: csr_rdata = cnt_q[CNT_W-1:DATA_W];
      SEL_CTRL:    csr_rdata = ctrl_q;
      default:     csr_rdata = sig_in;
    endcase
  end

  assign io_out  = gp_out_q;
  assign irq_out = ctrl_q[CTRL_IRQ_BIT];
  assign sig_out = ctrl_q[DATA_W-1:CTRL_SIG_LSB];
endmodule

// File: rtl/csr_seg_file_chk.sv
module csr_seg_file_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  csr_sel,
  input logic        csr_we,
  input logic [7:0]  csr_wdata,
  input logic        retire,
  input logic        fetch_valid,
  input logic [7:0]  fetch_pc,
  input logic        fetch_denied,
  input logic [7:0]  io_out,
  input logic [5:0]  sig_out,
  input logic        irq_out,
  input logic [15:0] cnt_q,
  input logic        cnt_en
);
  logic [7:0] shadow_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         shadow_lo <= 8'h01;
    else if (csr_we && csr_sel == 3'd0) shadow_lo <= csr_wdata;
  end

  assert_guard_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_pc[7]) |-> (fetch_denied == !shadow_lo[fetch_pc[6:4]]));

  assert_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !fetch_denied);

  assert_ctrl_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 3'd6) |=>
      (irq_out == $past(csr_wdata[0]) && sig_out == $past(csr_wdata[7:2])));

  assert_gp_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 3'd3) |=> (io_out == $past(csr_wdata)));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && cnt_en && !(csr_we && (csr_sel == 3'd4 || csr_sel == 3'd5)))
      |=> (cnt_q == $past(cnt_q) + 16'd1));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !(csr_we && (csr_sel == 3'd4 || csr_sel == 3'd5))) |=> $stable(cnt_q));

  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (csr_sel == 3'd2 || csr_sel == 3'd7))
      |=> ($stable(io_out) && $stable(sig_out) && $stable(irq_out)));
endmodule

bind csr_seg_file csr_seg_file_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_sel      (csr_sel),
  .csr_we       (csr_we),
  .csr_wdata    (csr_wdata),
  .retire       (retire),
  .fetch_valid  (fetch_valid),
  .fetch_pc     (fetch_pc),
  .fetch_denied (fetch_denied),
  .io_out       (io_out),
  .sig_out      (sig_out),
  .irq_out      (irq_out),
  .cnt_q        (cnt_q),
  .cnt_en       (cnt_en)
);

// File: tb/csr_seg_file_tb.sv
module csr_seg_file_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] csr_sel = '0;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic       retire = 1'b0;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_pc = '0;
  logic       fetch_denied;
  logic [7:0] io_in = 8'hA5;
  logic [7:0] io_out;
  logic [7:0] sig_in = 8'h3C;
  logic [5:0] sig_out;
  logic       irq_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  csr_seg_file u_dut (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .retire(retire),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_denied(fetch_denied),
    .io_in(io_in), .io_out(io_out), .sig_in(sig_in), .sig_out(sig_out),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive on the falling edge, one rising edge applies it
  task automatic cycle(input logic we, input logic [2:0] sel, input logic [7:0] d,
                       input logic ret);
    @(negedge clk);
    csr_we = we; csr_sel = sel; csr_wdata = d; retire = ret;
    @(negedge clk);
    csr_we = 1'b0; retire = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    cycle(1'b1, sel, d, 1'b0);
  endtask

  function automatic int rd_now();
    return int'(csr_rdata);
  endfunction

  task automatic rd(input logic [2:0] sel, output int v);
    csr_sel = sel; #1; v = int'(csr_rdata);
  endtask

  task automatic fetch(input logic v, input logic [7:0] pc, output int d);
    fetch_valid = v; fetch_pc = pc; #1; d = int'(fetch_denied);
    fetch_valid = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    rd(3'd0, v); chk("R1 exe_lo", v, 8'h01);
    rd(3'd1, v); chk("R1 exe_hi", v, 0);
    rd(3'd3, v); chk("R1 gp_out", v, 0);
    rd(3'd4, v); chk("R1 cnt_lo", v, 0);
    rd(3'd5, v); chk("R1 cnt_hi", v, 0);
    rd(3'd6, v); chk("R1 ctrl", v, 0);
    chk("R1 pins", {io_out, sig_out, irq_out, fetch_denied}, 0);
    fetch(1'b1, 8'h05, v); chk("R4 seg0 allowed", v, 0);
    fetch(1'b1, 8'h15, v); chk("R4 seg1 denied", v, 1);
    fetch(1'b1, 8'hF0, v); chk("R4 seg15 denied", v, 1);
    fetch(1'b0, 8'h15, v); chk("R3 no fetch no deny", v, 0);
  endtask

  task automatic t_readmux();
    int v;
    rd(3'd2, v); chk("R2 io_in view", v, 8'hA5);
    rd(3'd7, v); chk("R2 sig_in view", v, 8'h3C);
    io_in = 8'h5A; rd(3'd2, v); chk("R2 io_in live", v, 8'h5A);
  endtask

  task automatic t_guard();
    int v;
    wr(3'd0, 8'h0F); wr(3'd1, 8'h0F);
    rd(3'd1, v); chk("R2 exe_hi readback", v, 8'h0F);
    fetch(1'b1, 8'h30, v); chk("R3 seg3", v, 0);
    fetch(1'b1, 8'h40, v); chk("R3 seg4", v, 1);
    fetch(1'b1, 8'h80, v); chk("R3 seg8", v, 0);
    fetch(1'b1, 8'hBF, v); chk("R3 seg11", v, 0);
    fetch(1'b1, 8'hC0, v); chk("R3 seg12", v, 1);
    fetch(1'b1, 8'hF1, v); chk("R3 seg15", v, 1);
    wr(3'd1, 8'h80); wr(3'd0, 8'h00);
    fetch(1'b1, 8'hF1, v); chk("R3 seg15 open", v, 0);
    fetch(1'b1, 8'h05, v); chk("R3 seg0 closed", v, 1);
    fetch(1'b1, 8'h85, v); chk("R3 seg8 closed", v, 1);
  endtask

  task automatic t_outputs();
    wr(3'd3, 8'h96); chk("R6 io_out", io_out, 8'h96);
    wr(3'd6, 8'hA9); chk("R5 irq", irq_out, 1); chk("R5 sig", sig_out, 6'h2A);
    wr(3'd6, 8'h54); chk("R5 irq clr", irq_out, 0); chk("R5 sig2", sig_out, 6'h15);
  endtask

  task automatic t_ignored();
    int v;
    wr(3'd2, 8'hFF); wr(3'd7, 8'hFF);
    chk("R10 io_out kept", io_out, 8'h96);
    chk("R10 sig kept", sig_out, 6'h15); chk("R10 irq kept", irq_out, 0);
    rd(3'd2, v); chk("R10 io_in view", v, 8'h5A);
    rd(3'd7, v); chk("R10 sig_in view", v, 8'h3C);
    rd(3'd0, v); chk("R10 exe_lo kept", v, 8'h00);
    rd(3'd4, v); chk("R10 cnt kept", v, 0);
  endtask

  task automatic t_count_enable();
    int v;
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    cycle(1'b1, 3'd6, 8'h02, 1'b1);
    rd(3'd4, v); chk("R7 enable edge no step", v, 0);
    cycle(1'b0, 3'd4, 8'h00, 1'b1);
    rd(3'd4, v); chk("R7 first step", v, 1);
    @(negedge clk); csr_sel = 3'd4; retire = 1'b1; #1; v = rd_now();
    chk("R7 read during retire", v, 1);
    @(negedge clk); retire = 1'b0; #1; v = rd_now();
    chk("R7 following read", v, 2);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R7 hold no retire", v, 2);
    wr(3'd6, 8'h00);
    cycle(1'b0, 3'd4, 8'h00, 1'b1); cycle(1'b0, 3'd4, 8'h00, 1'b1);
    rd(3'd4, v); chk("R7 disabled hold", v, 2);
  endtask

  task automatic t_carry();
    int v;
    wr(3'd6, 8'h02);
    wr(3'd4, 8'hFF); wr(3'd5, 8'h12);
    cycle(1'b0, 3'd4, 8'h00, 1'b1);
    rd(3'd4, v); chk("R8 lo wrap", v, 0);
    rd(3'd5, v); chk("R8 carry", v, 8'h13);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    cycle(1'b0, 3'd4, 8'h00, 1'b1);
    rd(3'd4, v); chk("R8 full wrap lo", v, 0);
    rd(3'd5, v); chk("R8 full wrap hi", v, 0);
  endtask

  task automatic t_preset();
    int v;
    wr(3'd4, 8'h10); wr(3'd5, 8'h07);
    cycle(1'b1, 3'd4, 8'h40, 1'b1);
    rd(3'd4, v); chk("R9 lo preset wins", v, 8'h40);
    rd(3'd5, v); chk("R9 hi kept", v, 8'h07);
    cycle(1'b1, 3'd5, 8'h22, 1'b1);
    rd(3'd4, v); chk("R9 lo no step", v, 8'h40);
    rd(3'd5, v); chk("R9 hi preset", v, 8'h22);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readmux();
    t_guard();
    t_outputs();
    t_ignored();
    t_count_enable();
    t_carry();
    t_preset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule